// File: doc/BRIEF.md
# Four-Stage Instruction Pipeline Sequencer

This block is a control model of an in-order instruction pipeline with four segments: fetch, decode with address formation, operand read, and execute. Instruction words and data words live in two separate internal memories, so a fetch and an operand read never compete for a port. A small accumulator-style instruction set moves through the segments at one instruction per clock when nothing interferes.

Two hazards are handled in hardware. When a control transfer reaches the decode segment, nothing further enters decode and the fetch address is frozen until the transfer resolves in execute. A taken transfer then restarts fetch at its target, and an untaken one releases the word already fetched. When execute is writing data memory and the operand segment wants to read it, the operand segment and everything behind it wait one clock and a bubble goes into execute. Registers are read and written in execute, so no register hazard exists.

Both memories are filled through a plain write port, normally while reset is held. Every instruction that leaves execute appears on a trace port with its address, opcode and result.

Top module: `ipipe_seq`

## Requirements
- R1: Synchronous active-high reset clears every segment, sets the fetch address to 0 and clears all 16 registers; during reset `trace_valid` is 0 and `fetch_pc` is 0, and the word at address 0 shows on the trace exactly 4 rising edges after the first edge with reset low.
- R2: The instruction word splits as opcode in bits 15:12, register select in bits 11:8 and address in bits 7:0. Opcode 0 does nothing, 1 loads the register from data memory, 2 stores the register to data memory, 3 adds the data word to the register (modulo 2^16), 4 branches to the address when the register is zero, 5 jumps unconditionally. Codes 6 to 15 act as opcode 0 and trace as opcode 0.
- R3: Instructions leave execute in program order; with no hazard between two neighbours, the second traces one clock after the first.
- R4: An instruction that reads data memory, following one that does not write it, still traces one clock after its predecessor, since fetch and operand read use separate memories.
- R5: While a branch or jump moves from decode to execute, no new word enters decode and the fetch address holds; in the clock where the branch traces, `fetch_pc` equals the branch address plus 2 (modulo 256).
- R6: A taken branch or a jump discards the word fetched behind it; the instruction at the target traces 4 clocks after the branch.
- R7: An untaken branch lets the held word proceed; the next sequential instruction traces 3 clocks after the branch.
- R8: When a store is in execute and a load or add is in the operand segment, the operand segment waits and execute receives a bubble; the reader traces 2 clocks after the store and sees the stored value.
- R9: The trace reports, for the instruction in execute, its address, opcode and a result: the value written to the register for load and add, the stored value for a store, 1 or 0 for a taken or untaken branch, 1 for a jump, 0 otherwise.
- R10: With `load_en` high, `load_word` is written at `load_addr` into instruction memory when `load_sel` is 0 and into data memory when it is 1; loaded data is what a later load returns.
- R11: The sequence of traced addresses and results equals that of executing the program one instruction at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Memory fill strobe |
| load_sel | input | 1 | Fill target: 0 instruction memory, 1 data memory |
| load_addr | input | 8 | Fill address |
| load_word | input | 16 | Fill data |
| fetch_pc | output | 8 | Address of the next word to fetch |
| trace_valid | output | 1 | Execute holds an instruction (not a bubble) |
| trace_pc | output | 8 | Address of the instruction in execute |
| trace_op | output | 4 | Opcode of the instruction in execute |
| trace_data | output | 16 | Result of the instruction in execute |

## Verification
A segment register that advances when it should hold, or holds when it should advance, shows at the trace as a wrong gap between two retirements within one to four clocks, or as a wrong address when a discarded word leaks through. A wrong register or data memory value shows in the result of the next load, add, store or conditional branch that touches it. The bench runs directed and random programs against a one-instruction-at-a-time model, comparing every retirement's address, opcode, result and clock.

// File: rtl/ipipe_pkg.sv
package ipipe_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 8;
    localparam int REG_W  = 4;
    localparam int OP_W   = WORD_W - ADDR_W - REG_W;
    localparam int NREG   = 1 << REG_W;

    typedef enum logic [OP_W-1:0] {
        OP_NOP   = 4'd0,
        OP_LOAD  = 4'd1,
        OP_STORE = 4'd2,
        OP_ADD   = 4'd3,
        OP_BRZ   = 4'd4,
        OP_JMP   = 4'd5
    } op_e;

    typedef struct packed {
        logic              valid;
        op_e               op;
        logic [REG_W-1:0]  rsel;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] pc;
        logic [WORD_W-1:0] opnd;
    } slot_t;

    function automatic op_e map_op(logic [OP_W-1:0] code);
        case (code)
            4'd1:    return OP_LOAD;
            4'd2:    return OP_STORE;
            4'd3:    return OP_ADD;
            4'd4:    return OP_BRZ;
            4'd5:    return OP_JMP;
            default: return OP_NOP;
        endcase
    endfunction

    function automatic slot_t decode(logic v, logic [WORD_W-1:0] ir, logic [ADDR_W-1:0] pc);
        slot_t s;
        s       = '0;
        s.valid = v;
        s.op    = map_op(ir[WORD_W-1 -: OP_W]);
        s.rsel  = ir[ADDR_W +: REG_W];
        s.addr  = ir[ADDR_W-1:0];
        s.pc    = pc;
        return s;
    endfunction

    function automatic logic is_xfer(slot_t s);
        return s.valid && (s.op == OP_BRZ || s.op == OP_JMP);
    endfunction

    function automatic logic needs_data(slot_t s);
        return s.valid && (s.op == OP_LOAD || s.op == OP_ADD);
    endfunction
endpackage

// File: rtl/ipipe_ram.sv
module ipipe_ram #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ipipe_regs.sv
module ipipe_regs #(
    parameter int RW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [RW-1:0] wsel,
    input  logic [DW-1:0] wdata,
    input  logic [RW-1:0] rsel,
    output logic [DW-1:0] rdata
);
    localparam int N = 1 << RW;

    logic [DW-1:0] file_q [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) file_q[i] <= '0;
        end else if (we) begin
            file_q[wsel] <= wdata;
        end
    end

    assign rdata = file_q[rsel];
endmodule

// File: rtl/ipipe_seq.sv
module ipipe_seq
    import ipipe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic              load_sel,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [WORD_W-1:0] load_word,
    output logic [ADDR_W-1:0] fetch_pc,
    output logic              trace_valid,
    output logic [ADDR_W-1:0] trace_pc,
    output logic [OP_W-1:0]   trace_op,
    output logic [WORD_W-1:0] trace_data
);
    logic [ADDR_W-1:0] pc;
    logic [WORD_W-1:0] fi_ir;
    logic [ADDR_W-1:0] fi_pc;
    logic              fi_valid;
    slot_t             da, fo, ex, fo_adv;

    logic [ADDR_W-1:0] fetch_addr;
    logic [WORD_W-1:0] imem_word, dm_rdata, rf_rdata, ex_result;
    logic              ex_xfer, ex_taken, front_xfer, fo_stall, ex_store, rf_we;
    logic              dm_we, dm_fill;
    logic [ADDR_W-1:0] dm_waddr;
    logic [WORD_W-1:0] dm_wdata;

    // hazard conditions
    assign ex_xfer    = is_xfer(ex);
    assign ex_taken   = ex.valid && (ex.op == OP_JMP || (ex.op == OP_BRZ && rf_rdata == '0));
    assign front_xfer = is_xfer(da) || is_xfer(fo);
    assign ex_store   = ex.valid && ex.op == OP_STORE;
    assign fo_stall   = ex_store && needs_data(fo);
    assign fetch_addr = ex_taken ? ex.addr : pc;

    // memories and registers
    assign dm_fill  = load_en && load_sel;
    assign dm_we    = dm_fill || ex_store;
    assign dm_waddr = dm_fill ? load_addr : ex.addr;
    assign dm_wdata = dm_fill ? load_word : rf_rdata;
    assign rf_we    = ex.valid && (ex.op == OP_LOAD || ex.op == OP_ADD);

    ipipe_ram #(.AW(ADDR_W), .DW(WORD_W)) u_imem (
        .clk(clk), .we(load_en && !load_sel), .waddr(load_addr), .wdata(load_word),
        .raddr(fetch_addr), .rdata(imem_word)
    );

    ipipe_ram #(.AW(ADDR_W), .DW(WORD_W)) u_dmem (
        .clk(clk), .we(dm_we), .waddr(dm_waddr), .wdata(dm_wdata),
        .raddr(fo.addr), .rdata(dm_rdata)
    );

    ipipe_regs #(.RW(REG_W), .DW(WORD_W)) u_regs (
        .clk(clk), .rst(rst), .we(rf_we), .wsel(ex.rsel), .wdata(ex_result),
        .rsel(ex.rsel), .rdata(rf_rdata)
    );

    // execute result
    always_comb begin
        case (ex.op)
            OP_LOAD:  ex_result = ex.opnd;
            OP_ADD:   ex_result = rf_rdata + ex.opnd;
            OP_STORE: ex_result = rf_rdata;
            OP_BRZ:   ex_result = {{(WORD_W-1){1'b0}}, ex_taken};
            OP_JMP:   ex_result = {{(WORD_W-1){1'b0}}, 1'b1};
            default:  ex_result = '0;
        endcase
    end

    always_comb begin
        fo_adv      = fo;
        fo_adv.opnd = dm_rdata;
    end

    // segment advance
    always_ff @(posedge clk) begin
        if (rst) begin
            pc       <= '0;
            fi_ir    <= '0;
            fi_pc    <= '0;
            fi_valid <= 1'b0;
            da       <= '0;
            fo       <= '0;
            ex       <= '0;
        end else if (fo_stall) begin
            ex <= '0;
        end else begin
            ex <= fo_adv;
            fo <= da;
            if (ex_taken) begin
                da       <= '0;
                fi_ir    <= imem_word;
                fi_pc    <= fetch_addr;
                fi_valid <= 1'b1;
                pc       <= fetch_addr + 1'b1;
            end else if (front_xfer) begin
                da <= '0;
            end else begin
                da       <= decode(fi_valid, fi_ir, fi_pc);
                fi_ir    <= imem_word;
                fi_pc    <= fetch_addr;
                fi_valid <= 1'b1;
                pc       <= fetch_addr + 1'b1;
            end
        end
    end

    assign fetch_pc    = pc;
    assign trace_valid = ex.valid;
    assign trace_pc    = ex.pc;
    assign trace_op    = ex.op;
    assign trace_data  = ex_result;

    // checks beside the logic
    assert_pc_restart_R6: assert property (@(posedge clk) disable iff (rst)
        ex_taken |=> (pc == ADDR_W'($past(ex.addr) + 1'b1)) && !trace_valid);

    assert_stall_bubble_R8: assert property (@(posedge clk) disable iff (rst)
        (ex_store && needs_data(fo)) |=> !trace_valid && $stable(fo));

    assert_decode_bubble_R5: assert property (@(posedge clk) disable iff (rst)
        (is_xfer(da) && !fo_stall) |=> !da.valid);

    assert_fetch_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (front_xfer && !ex_taken) |=> $stable(pc));
endmodule

// File: tb/test_ipipe_seq.sv
`timescale 1ns/1ps
module test_ipipe_seq;
    localparam int NRET = 300;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_en = 1'b0;
    logic        load_sel = 1'b0;
    logic [7:0]  load_addr = '0;
    logic [15:0] load_word = '0;
    logic [7:0]  fetch_pc, trace_pc;
    logic        trace_valid;
    logic [3:0]  trace_op;
    logic [15:0] trace_data;

    ipipe_seq i_ipipe_seq (
        .clk(clk), .rst(rst), .load_en(load_en), .load_sel(load_sel),
        .load_addr(load_addr), .load_word(load_word), .fetch_pc(fetch_pc),
        .trace_valid(trace_valid), .trace_pc(trace_pc), .trace_op(trace_op),
        .trace_data(trace_data)
    );

    always #2.5 clk = ~clk;

    int tests = 0;
    int fails = 0;
    int edges = 0;

    logic [15:0] prog  [256];
    logic [15:0] dinit [256];
    logic [7:0]  e_pc   [NRET];
    logic [3:0]  e_op   [NRET];
    logic [15:0] e_dat  [NRET];
    int          e_time [NRET];
    string       e_gtag [NRET];

    task automatic check(string tag, string what, longint act, longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        edges++;
        if (edges > 150000) begin
            fails++;
            tests++;
            $display("FAIL R11 watchdog: actual %0d expected %0d", edges, 150000);
            finish_run();
        end
    end

    // one-instruction-at-a-time model with retirement clocks
    task automatic build_expect();
        logic [15:0] regs [16];
        logic [15:0] dm   [256];
        logic [7:0]  p = '0;
        int          pclass = 0;
        int          t = 0;
        for (int i = 0; i < 16; i++) regs[i] = '0;
        for (int i = 0; i < 256; i++) dm[i] = dinit[i];
        for (int k = 0; k < NRET; k++) begin
            logic [15:0] w  = prog[p];
            logic [3:0]  op = (w[15:12] <= 4'd5) ? w[15:12] : 4'd0;
            logic [3:0]  r  = w[11:8];
            logic [7:0]  a  = w[7:0];
            logic [7:0]  np = p + 8'd1;
            int          cls = 0;
            int          gap;
            logic        rd = (op == 4'd1 || op == 4'd3);
            e_pc[k] = p;
            e_op[k] = op;
            case (op)
                4'd1: begin regs[r] = dm[a]; e_dat[k] = regs[r]; end
                4'd2: begin dm[a] = regs[r]; e_dat[k] = regs[r]; cls = 3; end
                4'd3: begin regs[r] = regs[r] + dm[a]; e_dat[k] = regs[r]; end
                4'd4: begin
                    if (regs[r] == 16'd0) begin e_dat[k] = 16'd1; np = a; cls = 1; end
                    else begin e_dat[k] = 16'd0; cls = 2; end
                end
                4'd5: begin e_dat[k] = 16'd1; np = a; cls = 1; end
                default: e_dat[k] = 16'd0;
            endcase
            if (k == 0) begin gap = 4; e_gtag[k] = "R1"; end
            else if (pclass == 1) begin gap = 4; e_gtag[k] = "R6"; end
            else if (pclass == 2) begin gap = 3; e_gtag[k] = "R7"; end
            else if (pclass == 3 && rd) begin gap = 2; e_gtag[k] = "R8"; end
            else begin gap = 1; e_gtag[k] = rd ? "R4" : "R3"; end
            t = t + gap;
            e_time[k] = t;
            pclass = cls;
            p = np;
        end
    endtask

    task automatic run_program(string name);
        int idx = 0;
        int cyc = 0;
        $display("  [TB] program %s", name);
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 512; i++) begin
            load_en   = 1'b1;
            load_sel  = (i >= 256);
            load_addr = 8'(i);
            load_word = (i >= 256) ? dinit[i-256] : prog[i];
            @(negedge clk);
        end
        load_en = 1'b0;
        check("R1", "trace_valid in reset", trace_valid, 0);
        check("R1", "fetch_pc in reset", fetch_pc, 0);
        build_expect();
        rst = 1'b0;
        while (idx < NRET && cyc < NRET * 5 + 20) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (trace_valid) begin
                check(e_gtag[idx], "retire clock", cyc, e_time[idx]);
                check("R11", "trace_pc", trace_pc, e_pc[idx]);
                check("R2", "trace_op", trace_op, e_op[idx]);
                case (e_op[idx])
                    4'd1:       check("R10", "load result", trace_data, e_dat[idx]);
                    4'd4, 4'd5: check("R9", "branch result", trace_data, e_dat[idx]);
                    default:    check("R11", "result", trace_data, e_dat[idx]);
                endcase
                if (e_op[idx] == 4'd4 || e_op[idx] == 4'd5)
                    check("R5", "frozen fetch_pc", fetch_pc, 8'(e_pc[idx] + 8'd2));
                idx++;
            end
        end
        check("R11", "retirements seen", idx, NRET);
    endtask

    function automatic logic [15:0] enc(int op, int r, int a);
        return {4'(op), 4'(r), 8'(a)};
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        // directed: memory RAW stall, taken and untaken branches, discarded word
        for (int i = 0; i < 256; i++) begin prog[i] = '0; dinit[i] = '0; end
        dinit[5] = 16'd7;
        prog[0]  = enc(1, 1, 5);   // R1 <- 7
        prog[1]  = enc(2, 1, 6);   // D6 <- 7
        prog[2]  = enc(1, 2, 6);   // stall, R2 <- 7
        prog[3]  = enc(3, 2, 5);   // R2 <- 14
        prog[4]  = enc(4, 3, 10);  // taken
        prog[5]  = enc(1, 3, 5);   // must be discarded
        prog[10] = enc(4, 1, 20);  // not taken
        prog[11] = enc(9, 0, 0);   // unused code acts as no-op
        prog[12] = enc(3, 1, 6);   // R1 <- 14
        prog[13] = enc(5, 0, 0);   // jump back
        run_program("directed");

        for (int s = 0; s < 3; s++) begin
            for (int i = 0; i < 256; i++) begin
                int sel = $urandom_range(0, 9);
                int r   = $urandom_range(0, 3);
                int a   = $urandom_range(0, 7);
                case (sel)
                    0, 1: prog[i] = enc(1, r, a);
                    2, 3: prog[i] = enc(2, r, a);
                    4, 5: prog[i] = enc(3, r, a);
                    6:    prog[i] = enc(4, r, $urandom_range(0, 255));
                    7:    prog[i] = ($urandom_range(0, 3) == 0) ? enc(5, r, $urandom_range(0, 255))
                                                                : enc(3, r, a);
                    8:    prog[i] = enc(0, r, a);
                    default: prog[i] = enc($urandom_range(6, 15), r, a);
                endcase
                dinit[i] = (i < 8) ? 16'($urandom_range(0, 3)) : 16'($urandom);
            end
            run_program("random");
        end
        finish_run();
    end
endmodule